// File: doc/BRIEF.md
# Posted Burst Copy Engine with Byte Realignment

This block sits between an embedded core's load/store port and a Wishbone bus master. A word load whose address has its top bit set is taken as a burst read. The block fetches four consecutive bus words and packs them into four burst registers. A word store with the top bit set is taken as a burst write. The block then sends the four burst registers to the bus as four consecutive writes. The core sees each request finish in the cycle it is accepted. The bus traffic runs afterwards. The core stalls only if it presents another request while a burst is still running.

Source and destination need not share the same alignment. A programmable byte offset (0 to the word size minus one) shifts the incoming read bytes upward as they are packed. The bytes pushed past the last burst register go into a carry word. The next burst read places the carry bytes in the lowest lanes of its first register, so a chain of burst pairs copies a misaligned stream with no gaps. With the top address bit clear, the core reaches a small local window: the burst registers, the carry word and the offset register. It uses this window to fix up the head and tail of a transfer.

Top module: `bxe_burst_engine`

## Requirements
- R1: After reset the engine is idle with `cpu_ready` high and `wb_cyc`/`wb_stb` low, and the burst registers, the carry word and the offset all read 0.
- R2: An accepted read with `cpu_addr[AW-1]`=1 produces exactly four Wishbone read beats (`wb_we`=0). The first beat's address equals `cpu_addr` with bit AW-1 cleared, and each later beat's address is 4 above the previous one.
- R3: An accepted write with `cpu_addr[AW-1]`=1 produces exactly four Wishbone write beats (`wb_we`=1) at the same addresses as in R2. Beat i carries burst register i, for i = 0 to 3.
- R4: A request presented while the engine is idle is accepted in that cycle (`cpu_ready`=1). In the next cycle the bus burst is already running (`wb_cyc`=1) while the core is free.
- R5: While a burst or its one-cycle wind-down is in progress, `cpu_ready` is 0 and a presented request waits. With single-wait-state acknowledgements, a request presented right after a burst read is accepted 2*4+1 cycles later, and its bus beats follow all four beats of the earlier burst.
- R6: With offset k, packing works on a 20-byte stream. Stream bytes 0..k-1 are the low k bytes of the carry word, and stream bytes k..k+15 are the 16 read bytes in bus order. Stream byte j (0..15) lands in burst register j/4 at byte lane j%4, where lane 0 is bits 7:0. After the burst, the carry word holds stream bytes 16..15+k in lanes 0..k-1 and zeros above.
- R7: With offset 0, every burst register receives the read word unchanged and the carry word becomes 0.
- R8: With `cpu_addr[AW-1]`=0, the word index `cpu_addr[4:2]` selects a window register: 0 to 3 are the burst registers, 4 is the carry word and 5 is the offset. Writes store `cpu_wdata`; the offset keeps only bits 1:0. `cpu_rdata` always shows the selected register.
- R9: A beat holds `wb_stb`, `wb_adr` and `wb_we` steady until `wb_ack` is seen, however many wait cycles the slave inserts.
- R10: `wb_cyc` stays high through all four beats and drops in the cycle after the fourth acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Core request present |
| cpu_we | input | 1 | Core request is a store |
| cpu_addr | input | AW | Core byte address; top bit selects burst |
| cpu_wdata | input | DW | Core store data (window writes) |
| cpu_ready | output | 1 | Request accepted this cycle when high |
| cpu_rdata | output | DW | Window register selected by `cpu_addr` |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | AW | Wishbone byte address |
| wb_dat_o | output | DW | Wishbone write data |
| wb_sel | output | DW/8 | Byte selects, all set |
| wb_ack | input | 1 | Wishbone acknowledge |
| wb_dat_i | input | DW | Wishbone read data |

## Verification
The bus-side properties assume that the slave raises `wb_ack` only while `wb_stb` is high, and that read data is valid in the acknowledge cycle. The bench's slave model follows both rules, for any number of wait states. The checks on acceptance assume the core drives only word-aligned addresses and holds a request until it is accepted. The bench drives requests one at a time and keeps `cpu_valid` high through every stall. Window accesses are issued only between bursts, so packing and direct writes never target a register in the same cycle.

// File: rtl/bxe_pkg.sv
package bxe_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_DONE = 2'd3
   } bxe_state_t;
endpackage

// File: rtl/bxe_decode.sv
module bxe_decode #(
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int IDXW = 3
) (
   input  logic            cpu_valid,
   input  logic            cpu_we,
   input  logic [AW-1:0]   cpu_addr,
   input  logic            idle,
   output logic            go_rd,
   output logic            go_wr,
   output logic            win_wr,
   output logic [IDXW-1:0] win_idx,
   output logic [AW-1:0]   base_addr
);
   localparam int SH = $clog2(DW/8);

   logic burst, acc;

   assign burst     = cpu_addr[AW-1];
   assign acc       = cpu_valid & idle;
   assign go_rd     = acc & burst & ~cpu_we;
   assign go_wr     = acc & burst & cpu_we;
   assign win_wr    = acc & ~burst & cpu_we;
   assign win_idx   = cpu_addr[SH+IDXW-1:SH];
   assign base_addr = {1'b0, cpu_addr[AW-2:0]};
endmodule

// File: rtl/bxe_seq.sv
module bxe_seq
   import bxe_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int BEATS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     go_rd,
   input  logic                     go_wr,
   input  logic [AW-1:0]            base_addr,
   input  logic                     wb_ack,
   output logic                     wb_cyc,
   output logic                     wb_stb,
   output logic                     wb_we,
   output logic [AW-1:0]            wb_adr,
   output logic [$clog2(BEATS)-1:0] beat,
   output logic                     busy,
   output logic                     cap_en
);
   localparam int BW = $clog2(BEATS);
   localparam int SH = $clog2(DW/8);
   localparam logic [BW-1:0] LAST = BW'(BEATS-1);
   localparam logic [AW-1:0] STEP = AW'(DW/8);

   bxe_state_t    st_q;
   logic [BW-1:0] beat_q;
   logic [AW-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         beat_q <= '0;
         base_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               beat_q <= '0;
               if (go_rd || go_wr) begin
                  st_q   <= go_wr ? ST_WR : ST_RD;
                  base_q <= base_addr;
               end
            end
            ST_RD, ST_WR: begin
               if (wb_ack) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == LAST) st_q <= ST_DONE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign wb_cyc = (st_q == ST_RD) || (st_q == ST_WR);
   assign wb_stb = wb_cyc;
   assign wb_we  = (st_q == ST_WR);
   assign wb_adr = base_q + (AW'(beat_q) << SH);
   assign beat   = beat_q;
   assign busy   = (st_q != ST_IDLE);
   assign cap_en = (st_q == ST_RD) && wb_ack;

   // R9
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_stb && !wb_ack) |=> (wb_stb && $stable(wb_adr) && $stable(wb_we)));
   // R10
   cyc_through_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_stb && wb_ack && beat_q != LAST) |=> wb_cyc);
   // R10
   cyc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_stb && wb_ack && beat_q == LAST) |=> (!wb_cyc && busy));
   // R2
   adr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_stb && wb_ack && beat_q != LAST) |=> (wb_adr == $past(wb_adr) + STEP));
endmodule

// File: rtl/bxe_regs.sv
module bxe_regs #(
   parameter int DW    = 32,
   parameter int BEATS = 4,
   parameter int IDXW  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cap_en,
   input  logic [$clog2(BEATS)-1:0] beat,
   input  logic [DW-1:0]            cap_word,
   input  logic                     win_wr,
   input  logic [IDXW-1:0]          win_idx,
   input  logic [DW-1:0]            win_wdata,
   output logic [DW-1:0]            rd_data,
   output logic [DW-1:0]            out_word
);
   localparam int BW = $clog2(BEATS);
   localparam int OW = $clog2(DW/8);
   localparam logic [IDXW-1:0] IDX_CARRY = IDXW'(BEATS);
   localparam logic [IDXW-1:0] IDX_OFF   = IDXW'(BEATS + 1);

   logic [DW-1:0]   b_q [BEATS];
   logic [DW-1:0]   carry_q;
   logic [OW-1:0]   off_q;
   logic [2*DW-1:0] wide;
   logic [DW-1:0]   keep, lo, hi;

   // byte realignment: shift word up by off_q lanes, fill bottom from carry
   assign wide = {{DW{1'b0}}, cap_word} << {off_q, 3'b000};
   assign keep = ~({DW{1'b1}} << {off_q, 3'b000});
   assign lo   = wide[DW-1:0] | (carry_q & keep);
   assign hi   = wide[2*DW-1:DW];

   for (genvar g = 0; g < BEATS; g++) begin : g_breg
      always_ff @(posedge clk) begin
         if (!rst_n)
            b_q[g] <= '0;
         else if (cap_en && beat == BW'(g))
            b_q[g] <= lo;
         else if (win_wr && win_idx == IDXW'(g))
            b_q[g] <= win_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry_q <= '0;
         off_q   <= '0;
      end else begin
         if (cap_en)
            carry_q <= hi;
         else if (win_wr && win_idx == IDX_CARRY)
            carry_q <= win_wdata;
         if (win_wr && win_idx == IDX_OFF)
            off_q <= win_wdata[OW-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (win_idx < IDX_CARRY)    rd_data = b_q[win_idx[BW-1:0]];
      else if (win_idx == IDX_CARRY) rd_data = carry_q;
      else if (win_idx == IDX_OFF)   rd_data = DW'(off_q);
   end

   assign out_word = b_q[beat];

   // R7
   zero_offset_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && off_q == '0) |=> (carry_q == '0));
endmodule

// File: rtl/bxe_burst_engine.sv
module bxe_burst_engine #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int BEATS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_valid,
   input  logic            cpu_we,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   output logic            cpu_ready,
   output logic [DW-1:0]   cpu_rdata,
   output logic            wb_cyc,
   output logic            wb_stb,
   output logic            wb_we,
   output logic [AW-1:0]   wb_adr,
   output logic [DW-1:0]   wb_dat_o,
   output logic [DW/8-1:0] wb_sel,
   input  logic            wb_ack,
   input  logic [DW-1:0]   wb_dat_i
);
   localparam int BW   = $clog2(BEATS);
   localparam int IDXW = $clog2(BEATS + 2);

   if (DW % 8 != 0 || DW < 16) begin : g_bad_dw
      $error("bxe_burst_engine: DW must be a multiple of 8, at least 16");
   end
   if (BEATS < 2 || (1 << BW) != BEATS) begin : g_bad_beats
      $error("bxe_burst_engine: BEATS must be a power of two >= 2");
   end
   if (AW <= IDXW + $clog2(DW/8) + 1) begin : g_bad_aw
      $error("bxe_burst_engine: AW too narrow for the window");
   end

   logic            go_rd, go_wr, win_wr, busy, cap_en;
   logic [IDXW-1:0] win_idx;
   logic [AW-1:0]   base_addr;
   logic [BW-1:0]   beat;

   assign cpu_ready = ~busy;
   assign wb_sel    = '1;

   bxe_decode #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_dec (
      .cpu_valid (cpu_valid),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .idle      (cpu_ready),
      .go_rd     (go_rd),
      .go_wr     (go_wr),
      .win_wr    (win_wr),
      .win_idx   (win_idx),
      .base_addr (base_addr)
   );

   bxe_seq #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_rd     (go_rd),
      .go_wr     (go_wr),
      .base_addr (base_addr),
      .wb_ack    (wb_ack),
      .wb_cyc    (wb_cyc),
      .wb_stb    (wb_stb),
      .wb_we     (wb_we),
      .wb_adr    (wb_adr),
      .beat      (beat),
      .busy      (busy),
      .cap_en    (cap_en)
   );

   bxe_regs #(.DW(DW), .BEATS(BEATS), .IDXW(IDXW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .beat      (beat),
      .cap_word  (wb_dat_i),
      .win_wr    (win_wr),
      .win_idx   (win_idx),
      .win_wdata (cpu_wdata),
      .rd_data   (cpu_rdata),
      .out_word  (wb_dat_o)
   );

   // R4
   posted_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && cpu_addr[AW-1]) |=> wb_cyc);
   // R5
   stall_while_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cyc |-> !cpu_ready);
endmodule

// File: tb/bxe_burst_engine_test.sv
module bxe_burst_engine_test;
   localparam int AW = 32, DW = 32, BEATS = 4;
   localparam int VN = 6;
   localparam int VK   [VN] = '{0, 1, 2, 3, 1, 2};
   localparam int VSRC [VN] = '{0, 4, 8, 12, 16, 20};
   localparam int VDST [VN] = '{32, 36, 40, 44, 48, 52};
   localparam int VWAIT[VN] = '{0, 0, 2, 1, 3, 0};
   localparam logic [31:0] VSEED[VN] = '{32'h0, 32'hAABBCCDD, 32'h11223344,
                                         32'hCAFEF00D, 32'h01020304, 32'h99887766};
   localparam logic [31:0] A_CARRY = 32'd16, A_OFF = 32'd20, BURST = 32'h8000_0000;

   logic clk = 0, rst_n = 0;
   logic cpu_valid = 0, cpu_we = 0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic wb_cyc, wb_stb, wb_we, wb_ack;
   logic [AW-1:0] wb_adr;
   logic [DW-1:0] wb_dat_o, wb_dat_i;
   logic [DW/8-1:0] wb_sel;

   bxe_burst_engine #(.AW(AW), .DW(DW), .BEATS(BEATS)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .cpu_rdata(cpu_rdata), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
      .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_sel(wb_sel), .wb_ack(wb_ack),
      .wb_dat_i(wb_dat_i));

   always #10 clk = ~clk;

   function automatic logic [7:0] srcb(int b);
      return 8'(b) ^ 8'h5A;
   endfunction

   // Wishbone slave model
   logic [31:0] mem [64];
   logic [31:0] log_adr [256];
   logic        log_we  [256];
   int log_n = 0, wcnt = 0, beats_in = 0, fall_beats = 0, extra_wait = 0;
   logic prev_cyc = 0;
   assign wb_dat_i = mem[wb_adr[7:2]];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++)
            mem[i] <= {srcb(4*i+3), srcb(4*i+2), srcb(4*i+1), srcb(4*i)};
         wb_ack <= 0; wcnt <= 0; beats_in <= 0; prev_cyc <= 0;
      end else begin
         prev_cyc <= wb_cyc;
         if (wb_stb && !wb_ack) begin
            if (wcnt >= extra_wait) begin wb_ack <= 1; wcnt <= 0; end
            else wcnt <= wcnt + 1;
         end else wb_ack <= 0;
         if (wb_stb && wb_ack) begin
            if (wb_we) mem[wb_adr[7:2]] <= wb_dat_o;
            log_adr[log_n % 256] <= wb_adr;
            log_we[log_n % 256]  <= wb_we;
            log_n    <= log_n + 1;
            beats_in <= beats_in + 1;
         end
         if (!wb_cyc) begin
            if (prev_cyc) fall_beats <= beats_in;
            beats_in <= 0;
         end
      end
   end

   int checks = 0, errors = 0;
   bit done = 0;
   logic [31:0] expB [4];
   logic [31:0] expC;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cpu_req(input bit we, input logic [31:0] a, d, output int stalls);
      bit rdy;
      stalls = 0;
      @(negedge clk);
      cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      forever begin
         rdy = cpu_ready;
         @(posedge clk);
         if (rdy) break;
         stalls++;
         @(negedge clk);
      end
      #1 cpu_valid = 0;
   endtask

   task automatic win_rd(input int idx, output logic [31:0] v);
      @(negedge clk);
      cpu_addr = 32'(idx) << 2;
      #1 v = cpu_rdata;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!cpu_ready) @(negedge clk);
   endtask

   task automatic model(input int k, input int src, input logic [31:0] seed);
      logic [7:0] s [20];
      for (int j = 0; j < 20; j++) s[j] = 8'h00;
      for (int j = 0; j < k; j++) s[j] = seed[8*j +: 8];
      for (int m = 0; m < 16; m++) s[k+m] = srcb(src*4 + m);
      for (int i = 0; i < 4; i++) expB[i] = {s[4*i+3], s[4*i+2], s[4*i+1], s[4*i]};
      expC = 32'h0;
      for (int j = 0; j < k; j++) expC[8*j +: 8] = s[16+j];
   endtask

   task automatic chk_log(input int s, input int word, input bit we, input string req);
      logic [31:0] bad_a, bad_e;
      bit ok;
      ok = 1; bad_a = 0; bad_e = 0;
      for (int i = 0; i < 4; i++) begin
         if (ok && (log_adr[(s+i) % 256] != 32'((word + i) * 4) || log_we[(s+i) % 256] != we)) begin
            ok = 0; bad_a = log_adr[(s+i) % 256]; bad_e = 32'((word + i) * 4);
         end
      end
      if (log_n != s + 4) begin ok = 0; bad_a = 32'(log_n - s); bad_e = 32'd4; end
      chk(ok, req, bad_a, bad_e);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R5 watchdog actual=hung expected=idle");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int st, s;
      logic [31:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1 reset state
      @(negedge clk);
      chk(cpu_ready === 1'b1, "R1 ready", 32'(cpu_ready), 32'd1);
      chk(wb_cyc === 1'b0 && wb_stb === 1'b0, "R1 bus idle", 32'({wb_cyc, wb_stb}), 32'd0);
      win_rd(4, v); chk(v === 32'h0, "R1 carry", v, 32'h0);
      win_rd(5, v); chk(v === 32'h0, "R1 offset", v, 32'h0);
      win_rd(0, v); chk(v === 32'h0, "R1 breg0", v, 32'h0);

      // vector table: offset, carry seed, source, destination, slave wait states
      for (int n = 0; n < VN; n++) begin
         extra_wait = VWAIT[n];
         cpu_req(1, A_OFF, 32'(VK[n]), st);
         cpu_req(1, A_CARRY, VSEED[n], st);
         model(VK[n], VSRC[n], VSEED[n]);
         s = log_n;
         cpu_req(0, BURST | 32'(VSRC[n] * 4), 32'h0, st);
         wait_idle();
         chk_log(s, VSRC[n], 1'b0, "R2 read beats/addresses");
         chk(fall_beats == 4, "R10 cyc over four beats", 32'(fall_beats), 32'd4);
         win_rd(0, v); chk(v === expB[0], "R8 breg0 readback", v, expB[0]);
         win_rd(4, v);
         chk(v === expC, (VK[n] == 0) ? "R7 carry zero" : "R6 carry", v, expC);
         s = log_n;
         cpu_req(1, BURST | 32'(VDST[n] * 4), 32'h0, st);
         wait_idle();
         chk_log(s, VDST[n], 1'b1, "R3 write beats/addresses");
         for (int i = 0; i < 4; i++)
            chk(mem[VDST[n] + i] === expB[i], (VK[n] == 0) ? "R7 copy" : (VWAIT[n] > 0 ? "R9 data with waits" : "R6 packed"),
                mem[VDST[n] + i], expB[i]);
      end

      // R8 offset field width and direct burst register write
      cpu_req(1, A_OFF, 32'h7, st);
      win_rd(5, v); chk(v === 32'h3, "R8 offset width", v, 32'h3);
      cpu_req(1, 32'd8, 32'hDEADBEEF, st);
      expB[2] = 32'hDEADBEEF;
      cpu_req(1, BURST | 32'(60 * 4), 32'h0, st);
      wait_idle();
      for (int i = 0; i < 4; i++)
         chk(mem[60 + i] === expB[i], "R8 direct write then store", mem[60 + i], expB[i]);

      // R4 posted completion, R5 stall of a following request
      extra_wait = 0;
      cpu_req(1, A_OFF, 32'h0, st);
      s = log_n;
      cpu_req(0, BURST | 32'(0), 32'h0, st);
      chk(wb_cyc === 1'b1 && cpu_ready === 1'b0, "R4 posted", 32'({wb_cyc, cpu_ready}), 32'd2);
      cpu_req(1, BURST | 32'(56 * 4), 32'h0, st);
      chk(st == 2*BEATS + 1, "R5 stall cycles", 32'(st), 32'(2*BEATS + 1));
      wait_idle();
      chk(log_n == s + 8 && log_we[s % 256] == 0 && log_we[(s+3) % 256] == 0 &&
          log_we[(s+4) % 256] == 1 && log_we[(s+7) % 256] == 1,
          "R5 burst order", 32'(log_n - s), 32'd8);
      for (int i = 0; i < 4; i++)
         chk(mem[56 + i] === mem[i], "R7 chained copy", mem[56 + i], mem[i]);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule